// File: doc/BRIEF.md
# Load-Step Inductance Calibration Sequencer

This block steers one large load transient of a current-mode buck converter so that the transient itself serves as a measurement of the main and auxiliary inductors. When a step is flagged, the block stores the command that was in use and drives the command to its ceiling. It then walks the command through two raised levels and times three intervals with gated counters. The first interval ends at the capacitor-current zero crossing. The second ends when the inductor current reaches the calibration level. The third ends when it reaches the new operating level.

While the second interval runs, the block masks the peak-current comparator so that it cannot reset the PWM latch. The regulation loop is held for the whole sequence. It is released with a one-cycle preload of the new command once the last interval closes.

The quotient of the third interval over the first (the inductance ratio plus one) is formed by a restoring divider with a fixed-point fraction. The second interval is reported as the count proportional to the main inductance. When the division finishes, a done pulse is issued and, if the measurement is usable, a table write strobe. The timing table that is in use is therefore only replaced after the sequence ends, and it serves the next transient.

Top module: `lcal_seq`

## Requirements
- R1: After reset the block is idle: `seq_busy`, `pi_hold`, `pi_load`, `aux_hs_on`, `pk_mask`, `cal_done` and `tbl_we` are 0, all counts and `ratio` are 0, and `cmd_out` equals `cmd_in`.
- R2: A `step_det` seen while idle stores `cmd_in` and clears all three counts. From the next cycle, `cmd_out` is `CMD_MAX`, `aux_hs_on` and `pi_hold` are 1, and `seq_busy` is 1. `aux_hs_on` is high only during this first interval.
- R3: In the first interval, `t1_count` grows by one for every cycle in which `zc_det` is 0. A cycle with `zc_det` = 1 ends the interval, and `cmd_out` then becomes the stored command plus `dvcal`, clamped to `CMD_MAX`.
- R4: In the second interval, `pk_mask` is 1, `cmd_out` holds the calibration level, and `tcal_count` grows by one for every cycle in which `cur_reach` is 0. A cycle with `cur_reach` = 1 ends it.
- R5: In the third interval, `cmd_out` is the calibration level plus `dvc`, clamped to `CMD_MAX`, and `tres_count` counts cycles with `cur_reach` = 0. A `cur_reach` of 1 ends it. In the following cycle `pi_hold` is 0, `pi_load` is 1 for exactly one cycle, and `cmd_out` shows the new level. After that cycle, `cmd_out` follows `cmd_in`.
- R6: `ratio` equals floor(`tres_count`·2^FRAC / `t1_count`) on CW+FRAC bits, or all ones when `t1_count` is 0. `cal_done` is high for one cycle exactly CW+FRAC cycles after the cycle in which `pi_load` is high, and the block is idle in the cycle after `cal_done`.
- R7: Every count saturates at 2^CW−1 and never wraps.
- R8: `cal_valid` is 1 only when no count is saturated, `t1_count` is nonzero and `tres_count` ≥ `t1_count`. `tbl_we` is high exactly in the `cal_done` cycle, and only when `cal_valid` is 1.
- R9: `step_det` while the sequence runs is ignored: the stored command and the counts are not disturbed. `cur_reach` during the first interval has no effect.
- R10: Once the sequence has ended, counts and `ratio` hold their values until the next accepted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| step_det | input | 1 | large load step flagged by window comparators |
| zc_det | input | 1 | capacitor-current zero crossing |
| cur_reach | input | 1 | inductor current has reached the present command |
| cmd_in | input | CMDW | current command from the regulation loop |
| dvcal | input | CMDW | calibration increment |
| dvc | input | CMDW | increment from calibration level to new level |
| cmd_out | output | CMDW | command applied to the current comparator |
| pi_hold | output | 1 | regulation loop frozen |
| pi_load | output | 1 | one-cycle preload of `cmd_out` into the loop |
| aux_hs_on | output | 1 | auxiliary high-side switch forced on |
| pk_mask | output | 1 | peak-current comparator reset masked |
| t1_count | output | CW | first interval length |
| tcal_count | output | CW | calibration interval length (main inductance) |
| tres_count | output | CW | response interval length |
| ratio | output | CW+FRAC | tres/t1 with FRAC fraction bits |
| cal_valid | output | 1 | measurement usable |
| cal_done | output | 1 | sequence and division complete |
| tbl_we | output | 1 | write strobe for the timing table |
| seq_busy | output | 1 | sequence in progress |

## Verification
Command, mask and hold outputs change in the cycle after the input edge that moves the sequence, and each count shows its increment one cycle after the sampled low input. The quotient and `cal_done` arrive CW+FRAC cycles after the preload cycle. The bench carries a behavioural model that advances on the same clock edge as the design and compares every output at the falling edge, so each result is checked in the exact cycle it is due. Directed checks then measure the divider latency from the preload cycle and confirm that results persist while the block is idle.

// File: rtl/lcal_pkg.sv
package lcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_TCAL = 3'd2,
        ST_TRES = 3'd3,
        ST_DIV  = 3'd4
    } seq_state_e;

    localparam int NUM_CTR = 3;
    localparam int CTR_T1   = 0;
    localparam int CTR_TCAL = 1;
    localparam int CTR_TRES = 2;

    function automatic logic in_measure(input seq_state_e s);
        return (s == ST_T1) || (s == ST_TCAL) || (s == ST_TRES);
    endfunction

endpackage

// File: rtl/lcal_ctr.sv
module lcal_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          sat
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en && (cnt_q != TOP))
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
    assign sat = (cnt_q == TOP);

    // R7: a full counter never wraps to a smaller value
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP && !clr) |=> (cnt_q == TOP));
endmodule

// File: rtl/lcal_div.sv
module lcal_div #(
    parameter int CW   = 16,
    parameter int FRAC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CW-1:0]    num,
    input  logic [CW-1:0]    den,
    output logic             busy,
    output logic             done,
    output logic [CW+FRAC-1:0] quot
);
    localparam int N  = CW + FRAC;
    localparam int SW = $clog2(N + 1);

    logic [CW:0]   rem_q;
    logic [N-1:0]  acc_q;
    logic [CW-1:0] den_q;
    logic [SW-1:0] step_q;
    logic          busy_q, done_q;
    logic [N-1:0]  res_q;

    logic [CW:0]   shifted, diff;
    logic          ge;
    logic [N-1:0]  acc_nx;

    always_comb begin
        shifted = {rem_q[CW-1:0], acc_q[N-1]};
        ge      = (shifted >= {1'b0, den_q});
        diff    = shifted - {1'b0, den_q};
        acc_nx  = {acc_q[N-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            acc_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                acc_q  <= {num, {FRAC{1'b0}}};
                den_q  <= den;
                step_q <= SW'(N);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= ge ? diff : shifted;
                acc_q  <= acc_nx;
                step_q <= step_q - 1'b1;
                if (step_q == SW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= acc_nx;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = res_q;

    // R6: a new division is never launched over a running one
    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start);
    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/lcal_fsm.sv
module lcal_fsm
    import lcal_pkg::*;
#(
    parameter int              CMDW    = 12,
    parameter logic [CMDW-1:0] CMD_MAX = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_det,
    input  logic                zc_det,
    input  logic                cur_reach,
    input  logic [CMDW-1:0]     cmd_in,
    input  logic [CMDW-1:0]     dvcal,
    input  logic [CMDW-1:0]     dvc,
    input  logic                div_done,
    output seq_state_e          state,
    output logic [CMDW-1:0]     cmd_out,
    output logic                pi_load,
    output logic                ctr_clr,
    output logic [NUM_CTR-1:0]  ctr_en,
    output logic                div_start
);
    seq_state_e    state_q;
    logic [CMDW-1:0] saved_q, cal_q, new_q;
    logic          load_q;

    function automatic logic [CMDW-1:0] clamp_add(input logic [CMDW-1:0] a,
                                                    input logic [CMDW-1:0] b);
        logic [CMDW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s > {1'b0, CMD_MAX})
            return CMD_MAX;
        return s[CMDW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            saved_q <= '0;
            cal_q   <= '0;
            new_q   <= '0;
            load_q  <= 1'b0;
        end else begin
            load_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (step_det) begin
                    saved_q <= cmd_in;
                    state_q <= ST_T1;
                end
                ST_T1: if (zc_det) begin
                    cal_q   <= clamp_add(saved_q, dvcal);
                    state_q <= ST_TCAL;
                end
                ST_TCAL: if (cur_reach) begin
                    new_q   <= clamp_add(cal_q, dvc);
                    state_q <= ST_TRES;
                end
                ST_TRES: if (cur_reach) begin
                    load_q  <= 1'b1;
                    state_q <= ST_DIV;
                end
                ST_DIV: if (div_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctr_clr              = (state_q == ST_IDLE) && step_det;
        ctr_en               = '0;
        ctr_en[CTR_T1]       = (state_q == ST_T1)   && !zc_det;
        ctr_en[CTR_TCAL]     = (state_q == ST_TCAL) && !cur_reach;
        ctr_en[CTR_TRES]     = (state_q == ST_TRES) && !cur_reach;
        div_start            = (state_q == ST_TRES) && cur_reach;
        unique case (state_q)
            ST_T1:   cmd_out = CMD_MAX;
            ST_TCAL: cmd_out = cal_q;
            ST_TRES: cmd_out = new_q;
            ST_DIV:  cmd_out = load_q ? new_q : cmd_in;
            default: cmd_out = cmd_in;
        endcase
    end

    assign state   = state_q;
    assign pi_load = load_q;

    // R3: the calibration level never lies below the stored command
    p_cal_above_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TCAL) |-> (cal_q >= saved_q));
    // R9: a step flag during a running sequence leaves the stored command alone
    p_ign_step_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && step_det) |=> $stable(saved_q));
endmodule

// File: rtl/lcal_seq.sv
module lcal_seq
    import lcal_pkg::*;
#(
    parameter int              CW      = 16,
    parameter int              FRAC    = 8,
    parameter int              CMDW    = 12,
    parameter logic [CMDW-1:0] CMD_MAX = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_det,
    input  logic                 zc_det,
    input  logic                 cur_reach,
    input  logic [CMDW-1:0]      cmd_in,
    input  logic [CMDW-1:0]      dvcal,
    input  logic [CMDW-1:0]      dvc,
    output logic [CMDW-1:0]      cmd_out,
    output logic                 pi_hold,
    output logic                 pi_load,
    output logic                 aux_hs_on,
    output logic                 pk_mask,
    output logic [CW-1:0]        t1_count,
    output logic [CW-1:0]        tcal_count,
    output logic [CW-1:0]        tres_count,
    output logic [CW+FRAC-1:0]   ratio,
    output logic                 cal_valid,
    output logic                 cal_done,
    output logic                 tbl_we,
    output logic                 seq_busy
);
    seq_state_e          state;
    logic                ctr_clr, div_start, div_busy, div_done;
    logic [NUM_CTR-1:0]  ctr_en, ctr_sat;
    logic [CW-1:0]       ctr_val [NUM_CTR];

    lcal_fsm #(.CMDW(CMDW), .CMD_MAX(CMD_MAX)) u_fsm (
        .clk(clk), .rst(rst), .step_det(step_det), .zc_det(zc_det),
        .cur_reach(cur_reach), .cmd_in(cmd_in), .dvcal(dvcal), .dvc(dvc),
        .div_done(div_done), .state(state), .cmd_out(cmd_out),
        .pi_load(pi_load), .ctr_clr(ctr_clr), .ctr_en(ctr_en),
        .div_start(div_start)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        lcal_ctr #(.CW(CW)) u_ctr (
            .clk(clk), .rst(rst), .clr(ctr_clr), .en(ctr_en[i]),
            .cnt(ctr_val[i]), .sat(ctr_sat[i])
        );
    end

    lcal_div #(.CW(CW), .FRAC(FRAC)) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .num(ctr_val[CTR_TRES]), .den(ctr_val[CTR_T1]),
        .busy(div_busy), .done(div_done), .quot(ratio)
    );

    assign t1_count   = ctr_val[CTR_T1];
    assign tcal_count = ctr_val[CTR_TCAL];
    assign tres_count = ctr_val[CTR_TRES];

    assign pi_hold    = in_measure(state);
    assign aux_hs_on  = (state == ST_T1);
    assign pk_mask    = (state == ST_TCAL);
    assign seq_busy   = (state != ST_IDLE);
    assign cal_valid  = !(|ctr_sat) && (t1_count != '0) && (tres_count >= t1_count);
    assign cal_done   = (state == ST_DIV) && div_done;
    assign tbl_we     = cal_done && cal_valid;

    // R2: an accepted step forces the ceiling and the auxiliary switch next cycle
    p_step_force_r2: assert property (@(posedge clk) disable iff (rst)
        (!seq_busy && step_det) |=> (cmd_out == CMD_MAX && aux_hs_on && pi_hold));
    // R6: the block is idle right after completion
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> (!seq_busy && !pi_hold && !cal_done));
    // R5: the divider only runs after the loop has been released
    p_div_free_r5: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> !pi_hold);
endmodule

// File: tb/lcal_seq_bench.sv
module lcal_seq_bench;
    localparam int CLK_P = 10;
    localparam int CW    = 8;
    localparam int FRAC  = 6;
    localparam int CMDW  = 10;
    localparam int CMAX  = 1000;
    localparam int N     = CW + FRAC;
    localparam int CTOP  = (1 << CW) - 1;
    localparam int WD    = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_det = 0, zc_det = 0, cur_reach = 0;
    logic [CMDW-1:0] cmd_in = '0, dvcal = '0, dvc = '0;
    logic [CMDW-1:0] cmd_out;
    logic pi_hold, pi_load, aux_hs_on, pk_mask, cal_valid, cal_done, tbl_we, seq_busy;
    logic [CW-1:0] t1_count, tcal_count, tres_count;
    logic [N-1:0] ratio;

    int checks = 0, fails = 0, cyc = 0;
    bit started = 0;

    lcal_seq #(.CW(CW), .FRAC(FRAC), .CMDW(CMDW), .CMD_MAX(CMDW'(CMAX))) u_lcal_seq (
        .clk(clk), .rst(rst), .step_det(step_det), .zc_det(zc_det),
        .cur_reach(cur_reach), .cmd_in(cmd_in), .dvcal(dvcal), .dvc(dvc),
        .cmd_out(cmd_out), .pi_hold(pi_hold), .pi_load(pi_load),
        .aux_hs_on(aux_hs_on), .pk_mask(pk_mask), .t1_count(t1_count),
        .tcal_count(tcal_count), .tres_count(tres_count), .ratio(ratio),
        .cal_valid(cal_valid), .cal_done(cal_done), .tbl_we(tbl_we),
        .seq_busy(seq_busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: 0 idle, 1 first interval, 2 calibration, 3 response, 4 divide
    int mst, msaved, mcal, mnew, mt1, mtc, mtr, mwait, mq, mratio;
    bit mload, mdone;

    function automatic int cadd(input int a, input int b);
        return (a + b > CMAX) ? CMAX : a + b;
    endfunction

    function automatic int inc(input int a);
        return (a >= CTOP) ? CTOP : a + 1;
    endfunction

    function automatic int mvalid();
        return (mt1 != CTOP && mtc != CTOP && mtr != CTOP && mt1 != 0 && mtr >= mt1) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        bit ld_n, dn_n;
        cyc++;
        started = 1;
        ld_n = 0;
        dn_n = 0;
        if (rst) begin
            mst = 0; msaved = 0; mcal = 0; mnew = 0;
            mt1 = 0; mtc = 0; mtr = 0; mwait = 0; mq = 0; mratio = 0;
        end else begin
            case (mst)
                0: if (step_det) begin
                    msaved = int'(cmd_in); mt1 = 0; mtc = 0; mtr = 0; mst = 1;
                end
                1: if (zc_det) begin mcal = cadd(msaved, int'(dvcal)); mst = 2; end
                   else mt1 = inc(mt1);
                2: if (cur_reach) begin mnew = cadd(mcal, int'(dvc)); mst = 3; end
                   else mtc = inc(mtc);
                3: if (cur_reach) begin
                    mst = 4; ld_n = 1; mwait = N;
                    mq = (mt1 == 0) ? (1 << N) - 1 : (mtr << FRAC) / mt1;
                end else mtr = inc(mtr);
                default: if (mdone) mst = 0;
                    else begin
                        mwait--;
                        if (mwait == 0) begin dn_n = 1; mratio = mq; end
                    end
            endcase
        end
        mload = ld_n;
        mdone = dn_n;
        if (cyc >= WD) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD);
            $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            int ec;
            case (mst)
                1: ec = CMAX;
                2: ec = mcal;
                3: ec = mnew;
                4: ec = mload ? mnew : int'(cmd_in);
                default: ec = int'(cmd_in);
            endcase
            chk("R3 cmd_out", int'(cmd_out), ec);
            chk("R2 pi_hold", int'(pi_hold), (mst >= 1 && mst <= 3) ? 1 : 0);
            chk("R2 aux_hs_on", int'(aux_hs_on), (mst == 1) ? 1 : 0);
            chk("R4 pk_mask", int'(pk_mask), (mst == 2) ? 1 : 0);
            chk("R5 pi_load", int'(pi_load), int'(mload));
            chk("R3 t1_count", int'(t1_count), mt1);
            chk("R4 tcal_count", int'(tcal_count), mtc);
            chk("R5 tres_count", int'(tres_count), mtr);
            chk("R6 ratio", int'(ratio), mratio);
            chk("R6 cal_done", int'(cal_done), int'(mdone));
            chk("R8 cal_valid", int'(cal_valid), mvalid());
            chk("R8 tbl_we", int'(tbl_we), (mdone && mvalid() == 1) ? 1 : 0);
            chk("R9 seq_busy", int'(seq_busy), (mst != 0) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input int c, input int a1, input int ac, input int ar,
                           input int dcal, input int dv, input bit noise);
        int lat;
        cmd_in = CMDW'(c); dvcal = CMDW'(dcal); dvc = CMDW'(dv);
        step_det = 1; tick(); step_det = 0;
        for (int i = 0; i < a1; i++) begin
            step_det  = (noise && i == 1);
            cur_reach = (noise && i == 1);
            if (noise && i == 1) cmd_in = CMDW'(c + 7);
            tick();
        end
        step_det = 0; cur_reach = 0;
        zc_det = 1; tick(); zc_det = 0;
        repeat (ac) tick();
        cur_reach = 1; tick(); cur_reach = 0;
        repeat (ar) tick();
        cur_reach = 1; tick(); cur_reach = 0;
        chk("R5 preload", int'(pi_load), 1);
        lat = 0;
        while (!cal_done && lat < 4 * N) begin tick(); lat++; end
        chk("R6 latency", lat, N);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 idle busy", int'(seq_busy), 0);
        chk("R1 idle count", int'(t1_count), 0);
        chk("R1 idle cmd", int'(cmd_out), int'(cmd_in));
        rst = 0;
        cmd_in = 10'd123;
        tick();
        chk("R1 pass-through", int'(cmd_out), 123);

        run_seq(100, 5, 7, 20, 30, 50, 0);
        chk("R6 ratio value", int'(ratio), (20 << FRAC) / 5);
        chk("R8 valid", int'(cal_valid), 1);
        repeat (5) tick();
        chk("R10 t1 held", int'(t1_count), 5);
        chk("R10 tcal held", int'(tcal_count), 7);
        chk("R10 ratio held", int'(ratio), (20 << FRAC) / 5);

        run_seq(200, 3, 4, 11, 40, 60, 0);
        chk("R6 fraction", int'(ratio), (11 << FRAC) / 3);

        run_seq(300, 6, 5, 30, 20, 20, 1);
        chk("R9 t1 undisturbed", int'(t1_count), 6);

        run_seq(980, 300, 2, 4, 30, 50, 0);
        chk("R7 saturated", int'(t1_count), CTOP);
        chk("R7 invalid", int'(cal_valid), 0);

        run_seq(50, 9, 3, 4, 10, 10, 0);
        chk("R8 short response", int'(cal_valid), 0);

        run_seq(60, 0, 3, 5, 10, 10, 0);
        chk("R6 zero divisor", int'(ratio), (1 << N) - 1);
        chk("R8 zero t1", int'(cal_valid), 0);

        repeat (4) tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule